// File: doc/BRIEF.md
# Endian-Aware FIFO Port Adapter

This block joins a 16-bit CPU-side data port to a small byte-organised packet buffer. Each access moves either one byte or two bytes. A width input selects the access size. A byte-order input decides which data lane carries the byte at the lower buffer address. Writes append bytes to the buffer, and reads remove bytes from the front of it in the same order they were stored. A transmit sequence with an odd number of bytes is written as 16-bit words, with the last byte written as a single byte on the low lane.

An access is carried out only when the buffer can serve it. A write needs room for a full word. A read needs enough stored bytes for the requested width. In 8-bit mode only the low lane is valid. An access that breaks any of these rules leaves the buffer untouched and raises a sticky error flag, which only reset clears. The block reports how many bytes it currently holds, so that the buffer contents can be tracked from outside.

Top module: `fifo_port_adapter`

## Requirements
- R1: After reset, byte_cnt is 0, empty is 1, tx_rdy is 1, acc_err is 0 and rdata is 0.
- R2: In 16-bit mode (wide=1) with big_end=0, the byte at the lower buffer position travels on bits 7:0 and the next byte travels on bits 15:8. This holds for both writes and reads.
- R3: In 16-bit mode with big_end=1, the two lanes are swapped: the lower buffer position travels on bits 15:8 and the next byte travels on bits 7:0.
- R4: In 8-bit mode (wide=0), only bits 7:0 carry data, whatever the value of big_end. An accepted 8-bit read returns 0 on bits 15:8, and wdata[15:8] is ignored on 8-bit writes.
- R5: An accepted 16-bit access changes byte_cnt by 2. An accepted 8-bit access changes it by 1. Writes increase the count and reads decrease it.
- R6: tx_rdy is 1 exactly when byte_cnt is at most DEPTH-2, and empty is 1 exactly when byte_cnt is 0. A write while tx_rdy is 0 is ignored and sets acc_err.
- R7: A read that asks for more bytes than are held (any read while empty, or a 16-bit read with one byte held) removes nothing. It sets rdata to 0 on the next cycle and sets acc_err.
- R8: An 8-bit access with hi_lane=1 targets the prohibited upper lane. It is ignored, sets acc_err, and a read of this kind returns 0 on all of rdata.
- R9: Asserting wr_en and rd_en in the same cycle performs neither access and sets acc_err. If a read was requested, rdata becomes 0.
- R10: acc_err stays at 1 after it is set, through later legal accesses, until reset.
- R11: A byte sequence written as 16-bit words followed by one final 8-bit write is read back byte for byte in write order. This holds also when the sequence wraps past the end of the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request for this cycle |
| rd_en | input | 1 | Read request for this cycle |
| wide | input | 1 | 1: 16-bit access, 0: 8-bit access |
| big_end | input | 1 | 1: swap lanes on 16-bit access |
| hi_lane | input | 1 | 8-bit access aimed at bits 15:8 (prohibited) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after the read |
| tx_rdy | output | 1 | Room for a 16-bit write |
| empty | output | 1 | No bytes held |
| acc_err | output | 1 | Sticky illegal-access flag |
| byte_cnt | output | $clog2(DEPTH)+1 | Bytes currently held |

## Verification
Every combination of the three write modes with the three read modes (8-bit, 16-bit little-endian, 16-bit big-endian) is exercised on one byte stream. A lane swap, a dropped lane or a wrong byte count then shows up as a specific mismatch between the mode pairs. Odd-length streams that wrap the buffer check the ordering across the pointer wrap. Filling the buffer to capacity, reading while empty, 16-bit reads with only one byte held, upper-lane 8-bit accesses and simultaneous requests each test a separate rejection path. After every such case the count and the flags are checked, so that a rejected access that leaked into the buffer is detected.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

   typedef enum logic [1:0] {
      LANE_NARROW  = 2'd0,
      LANE_WIDE_LE = 2'd1,
      LANE_WIDE_BE = 2'd2
   } lane_mode_e;

   function automatic lane_mode_e pick_mode(input logic wide, input logic big_end);
      if (!wide)
         return LANE_NARROW;
      else if (big_end)
         return LANE_WIDE_BE;
      else
         return LANE_WIDE_LE;
   endfunction

endpackage

// File: rtl/fpa_byte_store.sv
module fpa_byte_store #(
   parameter int DEPTH = 16,
   parameter int PTR_W = $clog2(DEPTH),
   parameter int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             two,
   input  logic [7:0]       wb0,
   input  logic [7:0]       wb1,
   output logic [7:0]       pk0,
   output logic [7:0]       pk1,
   output logic [CNT_W-1:0] cnt
);

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [PTR_W-1:0] wr_ptr_n1, rd_ptr_n1;
   logic [PTR_W-1:0] step;
   logic [CNT_W-1:0] step_c;
   logic [7:0]       mem [DEPTH];

   assign wr_ptr_n1 = wr_ptr + PTR_W'(1);
   assign rd_ptr_n1 = rd_ptr + PTR_W'(1);
   assign step      = two ? PTR_W'(2) : PTR_W'(1);
   assign step_c    = two ? CNT_W'(2) : CNT_W'(1);

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [7:0] cell_q;
      always_ff @(posedge clk) begin
         if (push) begin
            if (wr_ptr == PTR_W'(i))
               cell_q <= wb0;
            else if (two && wr_ptr_n1 == PTR_W'(i))
               cell_q <= wb1;
         end
      end
      assign mem[i] = cell_q;
   end

   assign pk0 = mem[rd_ptr];
   assign pk1 = mem[rd_ptr_n1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) begin
            wr_ptr <= wr_ptr + step;
            cnt    <= cnt + step_c;
         end else if (pop) begin
            rd_ptr <= rd_ptr + step;
            cnt    <= cnt - step_c;
         end
      end
   end

   // R6
   cnt_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/fpa_lane_map.sv
module fpa_lane_map
   import fpa_pkg::*;
(
   input  lane_mode_e  mode,
   input  logic [15:0] wdata,
   input  logic [7:0]  pk0,
   input  logic [7:0]  pk1,
   output logic [7:0]  wb0,
   output logic [7:0]  wb1,
   output logic [15:0] rword
);

   always_comb begin
      case (mode)
         LANE_WIDE_LE: begin
            wb0   = wdata[7:0];
            wb1   = wdata[15:8];
            rword = {pk1, pk0};
         end
         LANE_WIDE_BE: begin
            wb0   = wdata[15:8];
            wb1   = wdata[7:0];
            rword = {pk0, pk1};
         end
         default: begin
            wb0   = wdata[7:0];
            wb1   = 8'h00;
            rword = {8'h00, pk0};
         end
      endcase
   end

endmodule

// File: rtl/fpa_access_ctrl.sv
module fpa_access_ctrl #(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             wide,
   input  logic             hi_lane,
   input  logic [CNT_W-1:0] cnt,
   output logic             push,
   output logic             pop,
   output logic             reject,
   output logic             tx_rdy
);

   localparam logic [CNT_W-1:0] ROOM_LIM = CNT_W'(DEPTH - 2);

   logic             lane_ok;
   logic [CNT_W-1:0] need;

   assign lane_ok = wide | ~hi_lane;
   assign need    = wide ? CNT_W'(2) : CNT_W'(1);
   assign tx_rdy  = (cnt <= ROOM_LIM);

   assign push   = wr_en & ~rd_en & tx_rdy & lane_ok;
   assign pop    = rd_en & ~wr_en & lane_ok & (cnt >= need);
   assign reject = (wr_en | rd_en) & ~push & ~pop;

endmodule

// File: rtl/fifo_port_adapter.sv
module fifo_port_adapter
   import fpa_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             wide,
   input  logic             big_end,
   input  logic             hi_lane,
   input  logic [15:0]      wdata,
   output logic [15:0]      rdata,
   output logic             tx_rdy,
   output logic             empty,
   output logic             acc_err,
   output logic [CNT_W-1:0] byte_cnt
);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (CNT_W != $clog2(DEPTH) + 1) begin : g_bad_cnt
      $error("CNT_W must equal clog2(DEPTH)+1");
   end

   lane_mode_e  mode;
   logic        push, pop, reject;
   logic [7:0]  wb0, wb1, pk0, pk1;
   logic [15:0] rword;

   assign mode = pick_mode(wide, big_end);

   fpa_access_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .wide   (wide),
      .hi_lane(hi_lane),
      .cnt    (byte_cnt),
      .push   (push),
      .pop    (pop),
      .reject (reject),
      .tx_rdy (tx_rdy)
   );

   fpa_lane_map map_i (
      .mode (mode),
      .wdata(wdata),
      .pk0  (pk0),
      .pk1  (pk1),
      .wb0  (wb0),
      .wb1  (wb1),
      .rword(rword)
   );

   fpa_byte_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) store_i (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push),
      .pop  (pop),
      .two  (wide),
      .wb0  (wb0),
      .wb1  (wb1),
      .pk0  (pk0),
      .pk1  (pk1),
      .cnt  (byte_cnt)
   );

   assign empty = (byte_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata   <= '0;
         acc_err <= 1'b0;
      end else begin
         if (pop)
            rdata <= rword;
         else if (rd_en)
            rdata <= '0;
         if (reject)
            acc_err <= 1'b1;
      end
   end

   // R5
   wide_write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && wide && tx_rdy) |=> byte_cnt == $past(byte_cnt) + CNT_W'(2));

   // R6
   full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && !tx_rdy) |=> (byte_cnt == $past(byte_cnt) && acc_err));

   // R7
   empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && empty) |=> (rdata == '0 && acc_err && empty));

   // R4
   narrow_read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && !wide) |=> rdata[15:8] == 8'h00);

   // R8
   upper_lane_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en ^ rd_en) && !wide && hi_lane) |=> (byte_cnt == $past(byte_cnt) && acc_err));

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |=> acc_err);

endmodule

// File: tb/fifo_port_adapter_tb.sv
`timescale 1ns/1ps
module fifo_port_adapter_tb_top;

   localparam int DEPTH = 16;
   localparam int CNT_W = $clog2(DEPTH) + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0, rd_en = 1'b0;
   logic             wide = 1'b0, big_end = 1'b0, hi_lane = 1'b0;
   logic [15:0]      wdata = '0;
   logic [15:0]      rdata;
   logic             tx_rdy, empty, acc_err;
   logic [CNT_W-1:0] byte_cnt;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   logic [7:0]  q[$];
   bit          exp_err;
   logic [15:0] exp_rdata;

   always #2.5 clk = ~clk;

   fifo_port_adapter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wide(wide),
      .big_end(big_end), .hi_lane(hi_lane), .wdata(wdata), .rdata(rdata),
      .tx_rdy(tx_rdy), .empty(empty), .acc_err(acc_err), .byte_cnt(byte_cnt)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_state(input string tag);
      chk({tag, " count R5"}, int'(byte_cnt), q.size());
      chk("R6 tx_rdy", int'(tx_rdy), int'(q.size() <= DEPTH - 2));
      chk("R6 empty", int'(empty), int'(q.size() == 0));
      chk("R10 acc_err", int'(acc_err), int'(exp_err));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      @(posedge clk); @(posedge clk);
      #1 rst_n = 1'b1;
      q.delete();
      exp_err = 1'b0;
      exp_rdata = '0;
      chk("R1 rdata", int'(rdata), 0);
      chk("R1 count", int'(byte_cnt), 0);
      chk("R1 empty", int'(empty), 1);
      chk("R1 tx_rdy", int'(tx_rdy), 1);
      chk("R1 acc_err", int'(acc_err), 0);
   endtask

   task automatic op(input bit w, input bit r, input bit wd, input bit be,
                     input bit hi, input logic [15:0] d, input string tag);
      logic [7:0] b0, b1;
      @(negedge clk);
      wr_en = w; rd_en = r; wide = wd; big_end = be; hi_lane = hi; wdata = d;
      @(posedge clk);
      #1 wr_en = 1'b0; rd_en = 1'b0;
      if (w && !r) begin
         if (q.size() <= DEPTH - 2 && (wd || !hi)) begin
            if (wd) begin
               q.push_back(be ? d[15:8] : d[7:0]);
               q.push_back(be ? d[7:0] : d[15:8]);
            end else
               q.push_back(d[7:0]);
         end else
            exp_err = 1'b1;
      end else if (r && !w) begin
         if ((wd || !hi) && q.size() >= (wd ? 2 : 1)) begin
            b0 = q.pop_front();
            if (wd) begin
               b1 = q.pop_front();
               exp_rdata = be ? {b0, b1} : {b1, b0};
            end else
               exp_rdata = {8'h00, b0};
         end else begin
            exp_rdata = '0;
            exp_err = 1'b1;
         end
      end else if (w && r) begin
         exp_err = 1'b1;
         exp_rdata = '0;
      end
      if (r) chk({tag, " rdata"}, int'(rdata), int'(exp_rdata));
      check_state(tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      do_reset();

      // R2 R3 R4: every write mode against every read mode
      for (int wm = 0; wm < 3; wm++) begin
         for (int rm = 0; rm < 3; rm++) begin
            string tg;
            logic [15:0] base;
            tg = (rm == 0) ? "R4" : (rm == 1) ? "R2" : "R3";
            base = 16'(16'h1020 * (wm * 3 + rm + 1) + 16'h0301);
            if (wm == 0) begin
               for (int k = 0; k < 4; k++)
                  op(1, 0, 0, k[0], 0, {8'hEE, base[7:0] + 8'(k)}, "R4 wr");
            end else begin
               op(1, 0, 1, wm == 2, 0, base, wm == 2 ? "R3 wr" : "R2 wr");
               op(1, 0, 1, wm == 2, 0, base ^ 16'h5A5A, wm == 2 ? "R3 wr" : "R2 wr");
            end
            if (rm == 0) begin
               for (int k = 0; k < 4; k++)
                  op(0, 1, 0, k[0], 0, 16'h0, tg);
            end else begin
               op(0, 1, 1, rm == 2, 0, 16'h0, tg);
               op(0, 1, 1, rm == 2, 0, 16'h0, tg);
            end
         end
      end

      // R11: odd streams, wrapping the buffer
      for (int rep = 0; rep < 5; rep++) begin
         for (int k = 0; k < 3; k++)
            op(1, 0, 1, rep[0], 0, 16'(16'hA100 + rep * 16 + k * 257), "R11 wr");
         op(1, 0, 0, 0, 0, 16'(16'h00C0 + rep), "R11 last");
         for (int k = 0; k < 7; k++)
            op(0, 1, 0, 0, 0, 16'h0, "R11");
      end

      // R6: fill then overflow
      for (int k = 0; k < DEPTH / 2; k++)
         op(1, 0, 1, 0, 0, 16'(k * 16'h0101 + 16'h0F00), "R6 fill");
      chk("R6 full tx_rdy", int'(tx_rdy), 0);
      op(1, 0, 0, 0, 0, 16'h00FF, "R6 overflow");
      chk("R6 overflow err", int'(acc_err), 1);
      for (int k = 0; k < DEPTH / 2; k++)
         op(0, 1, 1, 0, 0, 16'h0, "R6 drain");

      // R7: empty read, short wide read
      do_reset();
      op(0, 1, 1, 0, 0, 16'h0, "R7 empty");
      do_reset();
      op(1, 0, 0, 0, 0, 16'h0033, "R7 wr");
      op(0, 1, 1, 1, 0, 16'h0, "R7 short");
      op(0, 1, 0, 0, 0, 16'h0, "R10 after");
      chk("R10 still set", int'(acc_err), 1);

      // R8: upper lane in 8-bit mode
      do_reset();
      op(1, 0, 0, 0, 1, 16'h7788, "R8 wr");
      do_reset();
      op(1, 0, 1, 0, 0, 16'h4455, "R8 setup");
      op(0, 1, 0, 1, 1, 16'h0, "R8 rd");
      op(0, 1, 1, 0, 0, 16'h0, "R8 after");

      // R9: simultaneous requests
      do_reset();
      op(1, 0, 1, 0, 0, 16'h1234, "R9 setup");
      op(1, 1, 1, 0, 0, 16'h9999, "R9 both");
      op(0, 1, 1, 0, 0, 16'h0, "R9 after");
      chk("R9 err", int'(acc_err), 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule